// File: doc/BRIEF.md
# Running-Sum Moving Average Filter

This block smooths a stream of 8-bit unsigned samples by reporting the mean of the eight most recent ones. It does not add up the whole window on every update. It keeps a running total instead: each update adds the arriving sample and removes the one that left the window. The total is then divided by eight with a 3-bit right shift. The departing sample comes from a history chain of byte-wide delay stages. Each stage holds two bytes in series, so one stage delays a sample by two updates.

Updates happen one at a time under external control. A step line goes through a rising-edge detector, which turns each low-to-high transition into exactly one enabled clock. A slow agent, such as software writing a control bit, can therefore walk the filter forward one sample per request, however long it holds the line high.

Top module: `ravg_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the output, the running total and every history byte to zero. Samples taken in before a reset have no effect on any output after it.
- R2: An update happens only at the first clock edge where `step_in` is 1 after having been 0 at the previous edge. Holding `step_in` high for many cycles gives exactly one update.
- R3: While no update happens, `sample_in` changes have no effect on `avg_out`, and the window contents are unchanged.
- R4: After each update, `avg_out` equals floor((sum of the last 8 accepted samples) / 8).
- R5: Before 8 samples have been accepted since reset, the missing window slots count as zero in the R4 sum.
- R6: `avg_out` still shows its old value in the cycle right after the update edge, and shows the new value from the following clock edge onward.
- R7: Eight consecutive samples of 255 give `avg_out` = 255, with no wrap of the running total.
- R8: A sample leaves the window exactly 8 updates after it entered: after a full window of 255 followed by k zero samples, `avg_out` = floor(255*(8-k)/8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_in | input | 1 | Step request; its rising edge advances the filter by one sample |
| sample_in | input | 8 | Unsigned sample accepted on an update |
| avg_out | output | 8 | Registered mean of the last 8 accepted samples |

## Verification
An incrementing ramp shows whether the right sample leaves the window: a tap that is one stage too short or too long gives a constant offset from the expected mean. Seeded random samples, mixed with random step lengths and idle gaps, test the add-and-subtract arithmetic and the edge detector together. A run of 255s followed by zeros checks both the saturated total and the exact exit point of each sample. Held step levels, sample changes while idle, and a reset in the middle of a stream each test one of the conditions that must leave the window unchanged or empty it.

// File: rtl/ravg_filter.sv
module ravg_filter #(
  parameter int DW     = 8,
  parameter int STAGES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_in,
  input  logic [DW-1:0] sample_in,
  output logic [DW-1:0] avg_out
);
  localparam int DEPTH = 2 * STAGES;
  localparam int SHIFT = $clog2(DEPTH);
  localparam int SW    = DW + SHIFT;

  logic          step_q;
  logic          en;
  logic [SW-1:0] sum_q;
  logic [DW-1:0] link [STAGES+1];
  logic [DW-1:0] tail;

  always_ff @(posedge clk) begin
    if (rst) step_q <= 1'b0;
    else     step_q <= step_in;
  end

  assign en      = step_in & ~step_q;
  assign link[0] = sample_in;
  assign tail    = link[STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [DW-1:0] lo_q, hi_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (en) begin
        lo_q <= link[g];
        hi_q <= lo_q;
      end
    end
    assign link[g+1] = hi_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     sum_q <= '0;
    else if (en) sum_q <= sum_q + SW'(sample_in) - SW'(tail);
  end

  always_ff @(posedge clk) begin
    if (rst) avg_out <= '0;
    else     avg_out <= sum_q[SW-1:SHIFT];
  end
endmodule

module ravg_filter_chk #(
  parameter int DW = 8,
  parameter int SW = 11,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [SW-1:0] sum_q,
  input logic [DW-1:0] avg_out
);
  localparam int SHIFT = SW - DW;
  localparam logic [SW-1:0] SUM_MAX = SW'(DEPTH * ((1 << DW) - 1));

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sum_q == '0 && avg_out == '0)); // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) en |=> !en); // R2
  AST_IDLE_HOLDS:   assert property (@(posedge clk) disable iff (rst) !en |=> $stable(sum_q)); // R3
  AST_OUT_FOLLOWS:  assert property (@(posedge clk) disable iff (rst) 1'b1 |=> avg_out == $past(sum_q[SW-1:SHIFT])); // R6
  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) sum_q <= SUM_MAX); // R7
endmodule

bind ravg_filter ravg_filter_chk #(.DW(DW), .SW(SW), .DEPTH(DEPTH)) i_ravg_filter_chk (
  .clk(clk), .rst(rst), .en(en), .sum_q(sum_q), .avg_out(avg_out)
);

// File: tb/test_ravg_filter.sv
module test_ravg_filter;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_in = 1'b0;
  logic [7:0] sample_in = '0;
  logic [7:0] avg_out;

  int n_chk = 0;
  int n_bad = 0;
  int hist [8];

  ravg_filter i_ravg_filter (
    .clk(clk), .rst(rst), .step_in(step_in), .sample_in(sample_in), .avg_out(avg_out)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int model_avg();
    int s = 0;
    for (int i = 0; i < 8; i++) s += hist[i];
    return s / 8;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) hist[i] = 0;
  endtask

  task automatic model_push(input int v);
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
  endtask

  // one-cycle step pulse; checks latency (R6) and the result (R4)
  task automatic step(input logic [7:0] v, input string tag);
    int old_avg;
    @(negedge clk);
    old_avg = avg_out;
    sample_in = v;
    step_in = 1'b1;
    model_push(v);
    @(negedge clk);
    step_in = 1'b0;
    check("R6 old value held after update edge", avg_out, old_avg);
    @(negedge clk);
    check(tag, avg_out, model_avg());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    model_clear();
    do_reset();
    check("R1 output zero after reset", avg_out, 0);

    // R5 partial window, then R4 incrementing ramp
    for (int i = 1; i <= 7; i++) step(8'(i * 9), "R5 partial window");
    for (int i = 0; i < 24; i++) step(8'(i * 3 + 1), "R4 ramp");

    // R3 idle sample changes
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sample_in = 8'($urandom);
    end
    @(negedge clk);
    check("R3 no change without step", avg_out, model_avg());
    step(8'd0, "R3 window intact after idle");

    // R2 held step gives one update
    @(negedge clk);
    sample_in = 8'd200;
    step_in = 1'b1;
    model_push(200);
    repeat (6) @(negedge clk);
    check("R2 held step single update", avg_out, model_avg());
    step_in = 1'b0;
    @(negedge clk);
    check("R2 after release", avg_out, model_avg());

    // R7 saturated window, R8 exit timing
    for (int i = 0; i < 8; i++) step(8'd255, "R7 full window of 255");
    check("R7 max average", avg_out, 255);
    for (int k = 1; k <= 8; k++) begin
      step(8'd0, "R8 decay");
      check("R8 exit after 8 updates", avg_out, (255 * (8 - k)) / 8);
    end

    // R1 reset mid-stream clears history
    for (int i = 0; i < 5; i++) step(8'd250, "R4 prefill");
    do_reset();
    check("R1 output cleared mid-stream", avg_out, 0);
    for (int i = 0; i < 10; i++) step(8'd0, "R1 no leftover history");
    step(8'd16, "R1 clean restart");

    // random stimulus with random step lengths and gaps
    for (int i = 0; i < 300; i++) begin
      int hold;
      int gap;
      hold = 1 + int'($urandom % 3);
      gap = int'($urandom % 3);
      @(negedge clk);
      sample_in = 8'($urandom);
      step_in = 1'b1;
      model_push(int'(sample_in));
      repeat (hold) @(negedge clk);
      step_in = 1'b0;
      repeat (gap) begin
        sample_in = 8'($urandom);
        @(negedge clk);
      end
      @(negedge clk);
      check("R4 random", avg_out, model_avg());
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule